// File: doc/BRIEF.md
# Buffered Compare Timer Channel

A single 16-bit timer channel built around one counter, one active compare register, a shadow buffer for that compare register and a period register. One mode field picks the count source. The counter can run freely on a count-enable, count rising edges of an external event pin, generate a pulse-width waveform, or act as an up/down position counter driven by a two-phase encoder on two pins.

Software programs the channel through a narrow write port with one address per register. The channel reports a compare-match pulse, an overflow pulse and an underflow pulse. It drives the waveform pin from a register. It also presents the live counter and the active compare value so that its state can be observed. The buffer lets a new compare value be staged and then applied at a defined point: on a compare match or on a counter clear. In waveform mode the buffer is always applied at the period boundary, so a duty change never cuts a pulse short.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter and the active compare register read 0, the period register holds all ones, the control register is 0 and `match_o`, `ovf_o`, `unf_o` and `wave_o` are all low.
- R2: In free mode (control bits [1:0] = 0) the counter adds one on every clock edge at which `cnt_en` is high, and holds its value while `cnt_en` is low.
- R3: In event mode (control bits [1:0] = 1) the counter adds one per rising edge of `ev_in`, counted three clock edges after the pin changes. A level held high counts once, and the phase pins have no effect.
- R4: When the counter takes a count step while equal to the active compare value, `match_o` is high for the following cycle. If control bit 4 is set (outside waveform mode), that step loads 0 instead of adding one.
- R5: An upward step from all ones to zero raises `ovf_o` for exactly one cycle.
- R6: With control bit 2 set, the buffer is copied into the active compare register on a match step when control bit 3 is 0, or on a counter clear when control bit 3 is 1. With bit 2 clear, no copy occurs.
- R7: In waveform mode (control bits [1:0] = 2) the counter runs 0 to the period value and then returns to 0. `wave_o` is active while the counter is below the compare value, so a period P and a compare C ≤ P give C active cycles in every P+1. Active is high when control bit 5 is 0 and low when bit 5 is 1.
- R8: In waveform mode a compare value of 0 holds `wave_o` inactive, and a compare value above the period holds it active.
- R9: In waveform mode with the buffer enabled, the copy happens only at the period wrap, whatever control bit 3 says.
- R10: In phase mode (control bits [1:0] = 3) each single-pin change of the synchronized pair steps the counter: +1 when `pha_in` leads (sequence 00,10,11,01), −1 when `phb_in` leads. A change of both pins at once is ignored, and so is `ev_in`.
- R11: In phase mode a downward step from zero wraps to all ones and raises `unf_o` for exactly one cycle.
- R12: A write to the counter address (1) takes priority over a count step in the same cycle. The other addresses are control 0, compare 2, buffer 3 and period 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| cnt_en | input | 1 | Count enable |
| ev_in | input | 1 | External event pin |
| pha_in | input | 1 | Encoder phase A pin |
| phb_in | input | 1 | Encoder phase B pin |
| cnt_o | output | CNT_W | Live counter value |
| cmp_o | output | CNT_W | Active compare value |
| match_o | output | 1 | Compare-match pulse |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| wave_o | output | 1 | Waveform pin |

## Verification
A wrong counter value shows on `cnt_o` at the next sample, and a wrong compare value shows on `cmp_o` in the cycle after the missed or early buffer copy. A bad decode of the phase pins appears three cycles after the pin change as a count that moves in the wrong direction or moves when it should not. An error in the waveform path only shows as a wrong number of active samples over one full period, so duty checks count the active samples over a whole period rather than sampling at one point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_EVENT = 2'd1,
    MODE_PWM   = 2'd2,
    MODE_QUAD  = 2'd3
  } tmr_mode_e;

  // bit5 active_low, bit4 clr_on_match, bit3 buf_on_clear, bit2 buf_en, bits1:0 mode
  typedef struct packed {
    logic      active_low;
    logic      clr_on_match;
    logic      buf_on_clear;
    logic      buf_en;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CNT  = 3'd1;
  localparam logic [2:0] ADDR_CMP  = 3'd2;
  localparam logic [2:0] ADDR_BUF  = 3'd3;
  localparam logic [2:0] ADDR_PER  = 3'd4;
endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= pins;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec (
  input  logic clk,
  input  logic rst,
  input  logic a_cur,
  input  logic b_cur,
  input  logic a_prev,
  input  logic b_prev,
  output logic up,
  output logic down
);
  logic a_chg, b_chg, differ;

  always_comb begin
    a_chg  = a_cur ^ a_prev;
    b_chg  = b_cur ^ b_prev;
    differ = a_cur ^ b_cur;
    up     = (a_chg & ~b_chg & differ) | (b_chg & ~a_chg & ~differ);
    down   = (a_chg & ~b_chg & ~differ) | (b_chg & ~a_chg & differ);
  end

  p_dir_exclusive_r10: assert property (@(posedge clk) disable iff (rst) !(up && down));
  p_both_change_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (a_cur != a_prev && b_cur != b_prev) |-> (!up && !down));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         pwm_mode,
  input  logic         clr_on_match,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         match_evt,
  output logic         clear_evt,
  output logic         match_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;

  logic at_match, at_period, up_ok, dn_ok, ovf_evt, unf_evt;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    at_match  = (cnt == cmp);
    at_period = (cnt == period);
    up_ok     = step_up & ~wr_cnt;
    dn_ok     = step_dn & ~wr_cnt;
    match_evt = (up_ok | dn_ok) & at_match;
    clear_evt = up_ok & (pwm_mode ? at_period : (clr_on_match & at_match));
    ovf_evt   = up_ok & ~clear_evt & (cnt == ALL_ONES);
    unf_evt   = dn_ok & (cnt == ZERO);
    if (wr_cnt)         cnt_nxt = wr_val;
    else if (clear_evt) cnt_nxt = ZERO;
    else if (up_ok)     cnt_nxt = cnt + 1'b1;
    else if (dn_ok)     cnt_nxt = cnt - 1'b1;
    else                cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ZERO;
      match_o <= 1'b0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      match_o <= match_evt;
      ovf_o   <= ovf_evt;
      unf_o   <= unf_evt;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn && !wr_cnt) |=> cnt == $past(cnt));
  p_match_flag_r4: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(cnt == cmp));
  p_ovf_to_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> cnt == ZERO);
  p_unf_to_ones_r11: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> cnt == ALL_ONES);
  p_write_wins_r12: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt == $past(wr_val));
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cmp,
  input  logic         wr_buf,
  input  logic         wr_per,
  input  logic [W-1:0] wr_val,
  input  logic         load,
  output logic [W-1:0] cmp,
  output logic [W-1:0] period
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp    <= '0;
      shadow <= '0;
      period <= '1;
    end else begin
      if (wr_cmp)    cmp <= wr_val;
      else if (load) cmp <= shadow;
      if (wr_buf) shadow <= wr_val;
      if (wr_per) period <= wr_val;
    end
  end

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !wr_cmp) |=> cmp == $past(cmp));
endmodule

// File: rtl/tmr_pwm_out.sv
module tmr_pwm_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm_mode,
  input  logic         active_low,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         wave_o
);
  logic active;

  always_comb active = pwm_mode & (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) wave_o <= 1'b0;
    else     wave_o <= active ^ active_low;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_en,
  input  logic             ev_in,
  input  logic             pha_in,
  input  logic             phb_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             wave_o
);
  localparam int PIN_N = 3;

  tmr_ctrl_t ctrl;
  logic [PIN_N-1:0] pin_cur, pin_prev;
  logic q_up, q_dn, ev_rise;
  logic step_up, step_dn, pwm_mode;
  logic wr_ctrl, wr_cnt, wr_cmp, wr_buf, wr_per;
  logic match_evt, clear_evt, load;
  logic [CNT_W-1:0] period;

  always_comb begin
    wr_ctrl = wr_en & (wr_addr == ADDR_CTRL);
    wr_cnt  = wr_en & (wr_addr == ADDR_CNT);
    wr_cmp  = wr_en & (wr_addr == ADDR_CMP);
    wr_buf  = wr_en & (wr_addr == ADDR_BUF);
    wr_per  = wr_en & (wr_addr == ADDR_PER);
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl <= '0;
    else if (wr_ctrl) ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  tmr_in_sync #(.N(PIN_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .pins({ev_in, phb_in, pha_in}),
    .cur (pin_cur),
    .prev(pin_prev)
  );

  tmr_quad_dec u_quad (
    .clk   (clk),
    .rst   (rst),
    .a_cur (pin_cur[0]),
    .b_cur (pin_cur[1]),
    .a_prev(pin_prev[0]),
    .b_prev(pin_prev[1]),
    .up    (q_up),
    .down  (q_dn)
  );

  always_comb begin
    ev_rise  = pin_cur[2] & ~pin_prev[2];
    pwm_mode = (ctrl.mode == MODE_PWM);
    unique case (ctrl.mode)
      MODE_FREE:  step_up = cnt_en;
      MODE_EVENT: step_up = cnt_en & ev_rise;
      MODE_PWM:   step_up = cnt_en;
      MODE_QUAD:  step_up = cnt_en & q_up;
      default:    step_up = 1'b0;
    endcase
    step_dn = cnt_en & (ctrl.mode == MODE_QUAD) & q_dn;
    load    = ctrl.buf_en &
              ((pwm_mode | ctrl.buf_on_clear) ? clear_evt : match_evt);
  end

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .pwm_mode    (pwm_mode),
    .clr_on_match(ctrl.clr_on_match),
    .wr_cnt      (wr_cnt),
    .wr_val      (wr_data),
    .cmp         (cmp_o),
    .period      (period),
    .cnt         (cnt_o),
    .match_evt   (match_evt),
    .clear_evt   (clear_evt),
    .match_o     (match_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
  );

  tmr_cmp_bank #(.W(CNT_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_cmp(wr_cmp),
    .wr_buf(wr_buf),
    .wr_per(wr_per),
    .wr_val(wr_data),
    .load  (load),
    .cmp   (cmp_o),
    .period(period)
  );

  tmr_pwm_out #(.W(CNT_W)) u_pwm (
    .clk       (clk),
    .rst       (rst),
    .pwm_mode  (pwm_mode),
    .active_low(ctrl.active_low),
    .cnt       (cnt_o),
    .cmp       (cmp_o),
    .wave_o    (wave_o)
  );

  // R9: in waveform mode the active compare only moves at the period wrap
  p_pwm_cmp_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && $past(pwm_mode) && !$past(wr_cmp) && cmp_o != $past(cmp_o))
      |-> cnt_o == '0);
  p_no_dual_flag_r5: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  import tmr_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic cnt_en = 1'b0, ev_in = 1'b0, pha_in = 1'b0, phb_in = 1'b0;
  logic [W-1:0] cnt_o, cmp_o;
  logic match_o, ovf_o, unf_o, wave_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_en(cnt_en), .ev_in(ev_in), .pha_in(pha_in), .phb_in(phb_in),
    .cnt_o(cnt_o), .cmp_o(cmp_o), .match_o(match_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .wave_o(wave_o)
  );

  // {pha, phb, expected counter}
  localparam logic [W+1:0] QUAD_VEC [13] = '{
    {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
    {2'b01, 16'h0003}, {2'b11, 16'h0002}, {2'b10, 16'h0001}, {2'b00, 16'h0000},
    {2'b01, 16'hFFFF}, {2'b10, 16'hFFFF}, {2'b00, 16'hFFFE}, {2'b10, 16'hFFFF},
    {2'b11, 16'h0000}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [5:0] c, input logic [W-1:0] cmp, input logic [W-1:0] cnt);
    cnt_en = 1'b0;
    wr(ADDR_CTRL, {{(W-6){1'b0}}, c});
    wr(ADDR_CMP, cmp);
    wr(ADDR_CNT, cnt);
  endtask

  task automatic duty(input string req, input int exp);
    int highs = 0;
    tick(25);
    for (int i = 0; i < 10; i++) begin
      if (wave_o) highs++;
      tick(1);
    end
    chk(req, W'(highs), W'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 cmp", cmp_o, 0);
    chk("R1 flags", W'({match_o, ovf_o, unf_o, wave_o}), 0);

    // R2 free running and hold
    cnt_en = 1'b1; tick(10);
    chk("R2 count", cnt_o, 10);
    cnt_en = 1'b0; tick(5);
    chk("R2 hold", cnt_o, 10);

    // R12 write beats a step
    cnt_en = 1'b1;
    wr(ADDR_CNT, 100);
    chk("R12 write wins", cnt_o, 100);
    tick(1);
    chk("R12 resume", cnt_o, 101);

    // R3 event counting
    setup(6'd1, 16'h0FFF, 0);
    cnt_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ev_in = 1'b1; tick(4); ev_in = 1'b0; tick(4);
    end
    chk("R3 three edges", cnt_o, 3);
    ev_in = 1'b1; tick(10); ev_in = 1'b0; tick(4);
    chk("R3 level once", cnt_o, 4);
    pha_in = 1'b1; tick(4); phb_in = 1'b1; tick(4);
    pha_in = 1'b0; tick(4); phb_in = 1'b0; tick(4);
    chk("R3 phase pins ignored", cnt_o, 4);

    // R4 match with clear
    setup(6'd16, 5, 0);
    cnt_en = 1'b1; tick(5);
    chk("R4 before match", W'(match_o), 0);
    tick(1);
    chk("R4 clear to zero", cnt_o, 0);
    chk("R4 match pulse", W'(match_o), 1);
    tick(1);
    chk("R4 pulse ends", W'(match_o), 0);
    chk("R4 count after clear", cnt_o, 1);
    setup(6'd0, 3, 0);
    cnt_en = 1'b1; tick(4);
    chk("R4 no clear count", cnt_o, 4);
    chk("R4 match no clear", W'(match_o), 1);

    // R5 overflow
    setup(6'd0, 3, 16'hFFFE);
    cnt_en = 1'b1; tick(1);
    chk("R5 pre wrap", W'(ovf_o), 0);
    tick(1);
    chk("R5 wrap value", cnt_o, 0);
    chk("R5 ovf pulse", W'(ovf_o), 1);
    tick(1);
    chk("R5 ovf ends", W'(ovf_o), 0);

    // R6 buffer on match
    setup(6'd4, 3, 0);
    wr(ADDR_BUF, 9);
    cnt_en = 1'b1; tick(3);
    chk("R6 before match", cmp_o, 3);
    tick(1);
    chk("R6 copy on match", cmp_o, 9);
    // R6 buffer on clear, no clear happening
    setup(6'd12, 2, 0);
    wr(ADDR_BUF, 7);
    cnt_en = 1'b1; tick(4);
    chk("R6 no copy without clear", cmp_o, 2);
    cnt_en = 1'b0;
    wr(ADDR_CTRL, 16'd28);
    wr(ADDR_CNT, 0);
    cnt_en = 1'b1; tick(3);
    chk("R6 clear count", cnt_o, 0);
    chk("R6 copy on clear", cmp_o, 7);
    // R6 buffer disabled
    setup(6'd0, 3, 0);
    wr(ADDR_BUF, 9);
    cnt_en = 1'b1; tick(5);
    chk("R6 disabled", cmp_o, 3);

    // R7 waveform duty
    cnt_en = 1'b0;
    wr(ADDR_PER, 9);
    setup(6'd2, 4, 0);
    cnt_en = 1'b1;
    duty("R7 duty 4 of 10", 4);
    cnt_en = 1'b0;
    wr(ADDR_CTRL, 16'd34);
    cnt_en = 1'b1;
    duty("R7 active low", 6);
    // R8 extremes
    setup(6'd2, 0, 0);
    cnt_en = 1'b1;
    duty("R8 zero duty", 0);
    setup(6'd2, 12, 0);
    cnt_en = 1'b1;
    duty("R8 full duty", 10);

    // R9 buffer waits for period wrap
    setup(6'd6, 4, 0);
    wr(ADDR_BUF, 7);
    cnt_en = 1'b1; tick(6);
    chk("R9 held past match", cmp_o, 4);
    tick(5);
    chk("R9 copy at wrap", cmp_o, 7);

    // R10 phase decoding table
    setup(6'd3, 16'h8000, 0);
    cnt_en = 1'b1;
    for (int i = 0; i < 13; i++) begin
      pha_in = QUAD_VEC[i][W+1];
      phb_in = QUAD_VEC[i][W];
      tick(4);
      chk($sformatf("R10 step %0d", i), cnt_o, QUAD_VEC[i][W-1:0]);
    end

    // R11 underflow: pins 11 -> 10 is a down step
    pha_in = 1'b1; phb_in = 1'b0;
    tick(3);
    chk("R11 wrap value", cnt_o, 16'hFFFF);
    chk("R11 unf pulse", W'(unf_o), 1);
    tick(1);
    chk("R11 unf ends", W'(unf_o), 0);

    // R10 event pin ignored in phase mode
    ev_in = 1'b1; tick(4); ev_in = 1'b0; tick(4);
    chk("R10 event ignored", cnt_o, 16'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule